// File: doc/BRIEF.md
# Watchdog Timer With Selectable Timeouts

This block is a watchdog counter that forces a system reset when software stops servicing it. It counts ticks from one of two count sources: the fast bus clock enable or a slow tick of roughly 1 kHz. It raises a one-cycle reset request when the count reaches the selected overflow value before a service write arrives. Software chooses the source and a short or long timeout through a small control register. The two select bits together give four overflow counts, each a parameter given as a power of two.

Software services the watchdog by writing to a status register address. The data of that write is discarded, and the write only restarts the count. The block comes out of every reset enabled, counting on the bus tick with the long timeout, so a system that never touches the control register is still protected. Clearing the enable bit stops the watchdog and holds its counter at zero. Changing either select bit also restarts the count, so a switch to a shorter timeout cannot fire at once on a count that built up under the old setting.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the watchdog is enabled, counts the bus tick and uses the long bus timeout (2^BUS_LONG_LG ticks). `rst_req` is 0 while `rst_n` is low.
- R2: Only the selected source advances the count. A tick on the unselected enable input has no effect.
- R3: A write to `SVC_ADDR` clears the count to zero whatever the write data holds.
- R4: The control register at `CTRL_ADDR` holds enable in bit 0, slow-source select in bit 1 and short-timeout select in bit 2. The overflow counts are 2^BUS_LONG_LG when both selects are 0, 2^BUS_SHORT_LG when only the short bit is set, 2^SLOW_LONG_LG when only the slow bit is set, and 2^SLOW_SHORT_LG when both are set.
- R5: `rst_req` is high for exactly the one cycle that follows the Nth counted tick since the last clear, where N is the selected overflow count. The count then restarts from zero.
- R6: While enable is 0 the count is held at zero and no reset request is issued. Service writes change nothing while the watchdog is disabled.
- R7: A control write that changes the slow-source bit or the short-timeout bit clears the count. A control write that leaves both bits unchanged does not clear it.
- R8: Writes to addresses other than `CTRL_ADDR` and `SVC_ADDR` have no effect on the count or the configuration.
- R9: When a service write and a counted tick fall in the same cycle, the service wins and the count is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| bus_tick | input | 1 | Bus-clock count enable |
| slow_tick | input | 1 | Slow (~1 kHz) count enable |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench times the cycle from a clear to the request in all four select combinations. A design with a swapped select decode, or an off-by-one compare, would fire at the wrong tick. A service write that lands in the same cycle as the terminal tick is aimed at designs that let the tick win; such a design would still pulse `rst_req`. A control write that repeats the current select bits must not restart the count, and a real select change must restart it. A design that gets either wrong fires early or late. Tick pulses on the unselected source, writes while disabled, and writes to stray addresses are all applied between clears, so a block that reacts to any of them shows a request at the wrong time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned CTRL_EN_BIT    = 0;
   localparam int unsigned CTRL_SLOW_BIT  = 1;
   localparam int unsigned CTRL_SHORT_BIT = 2;
   localparam int unsigned NUM_MODES      = 4;

   typedef struct packed {
      logic short_to;
      logic slow_src;
      logic en;
   } wdt_cfg_t;

   localparam wdt_cfg_t CFG_RESET = '{short_to: 1'b0, slow_src: 1'b0, en: 1'b1};

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
   parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output wdt_cfg_t          cfg,
   output logic              svc_hit,
   output logic              sel_change
);
   logic ctrl_wr;
   wdt_cfg_t cfg_q;

   assign ctrl_wr    = wr_en && (wr_addr == CTRL_ADDR);
   assign svc_hit    = wr_en && (wr_addr == SVC_ADDR);
   assign sel_change = ctrl_wr &&
                       ((wr_data[CTRL_SLOW_BIT]  != cfg_q.slow_src) ||
                        (wr_data[CTRL_SHORT_BIT] != cfg_q.short_to));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (ctrl_wr) begin
         cfg_q.en       <= wr_data[CTRL_EN_BIT];
         cfg_q.slow_src <= wr_data[CTRL_SLOW_BIT];
         cfg_q.short_to <= wr_data[CTRL_SHORT_BIT];
      end
   end

   assign cfg = cfg_q;

   generate
      if (DATA_W > 3) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:3];
      end
   endgenerate
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
   import wdt_pkg::*;
(
   input  wdt_cfg_t cfg,
   input  logic     bus_tick,
   input  logic     slow_tick,
   output logic     sel_tick
);
   always_comb begin
      sel_tick = cfg.slow_src ? slow_tick : bus_tick;
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int unsigned BUS_LONG_LG   = 18,
   parameter int unsigned BUS_SHORT_LG  = 13,
   parameter int unsigned SLOW_LONG_LG  = 8,
   parameter int unsigned SLOW_SHORT_LG = 5,
   localparam int unsigned CNT_W = max_of4(BUS_LONG_LG, BUS_SHORT_LG, SLOW_LONG_LG, SLOW_SHORT_LG)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  wdt_cfg_t cfg,
   input  logic     sel_tick,
   input  logic     clr,
   output logic     rst_req
);
   logic [CNT_W-1:0]     cnt_q;
   logic [NUM_MODES-1:0] at_term;
   logic [1:0]           mode;
   logic                 hit;

   assign mode = {cfg.slow_src, cfg.short_to};

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_term
      localparam int unsigned LG = (m == 0) ? BUS_LONG_LG  :
                                   (m == 1) ? BUS_SHORT_LG :
                                   (m == 2) ? SLOW_LONG_LG : SLOW_SHORT_LG;
      localparam logic [CNT_W:0] TERM_W = ({{CNT_W{1'b0}}, 1'b1} << LG) - 1'b1;
      assign at_term[m] = (cnt_q == TERM_W[CNT_W-1:0]);
   end

   assign hit = at_term[mode];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (!cfg.en || clr) begin
            cnt_q <= '0;
         end else if (sel_tick) begin
            if (hit) begin
               cnt_q   <= '0;
               rst_req <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
   parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'h14,
   parameter int unsigned BUS_LONG_LG   = 18,
   parameter int unsigned BUS_SHORT_LG  = 13,
   parameter int unsigned SLOW_LONG_LG  = 8,
   parameter int unsigned SLOW_SHORT_LG = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bus_tick,
   input  logic              slow_tick,
   output logic              rst_req
);
   localparam int unsigned MAX_LG = max_of4(BUS_LONG_LG, BUS_SHORT_LG, SLOW_LONG_LG, SLOW_SHORT_LG);

   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("svc_watchdog: DATA_W must hold the three control bits");
      end
      if (CTRL_ADDR == SVC_ADDR) begin : g_bad_addr
         $error("svc_watchdog: control and service addresses must differ");
      end
      if (BUS_SHORT_LG < 1 || SLOW_SHORT_LG < 1 || MAX_LG > 31) begin : g_bad_lg
         $error("svc_watchdog: timeout exponents must lie in 1..31");
      end
      if (BUS_SHORT_LG > BUS_LONG_LG || SLOW_SHORT_LG > SLOW_LONG_LG) begin : g_bad_order
         $error("svc_watchdog: short timeout must not exceed long timeout");
      end
   endgenerate

   wdt_cfg_t cfg;
   logic     svc_hit;
   logic     sel_change;
   logic     sel_tick;

   wdt_ctrl_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .SVC_ADDR(SVC_ADDR)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cfg(cfg), .svc_hit(svc_hit), .sel_change(sel_change)
   );

   wdt_tick_sel u_tick (
      .cfg(cfg), .bus_tick(bus_tick), .slow_tick(slow_tick), .sel_tick(sel_tick)
   );

   wdt_counter #(
      .BUS_LONG_LG(BUS_LONG_LG), .BUS_SHORT_LG(BUS_SHORT_LG),
      .SLOW_LONG_LG(SLOW_LONG_LG), .SLOW_SHORT_LG(SLOW_SHORT_LG)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .sel_tick(sel_tick),
      .clr(svc_hit | sel_change), .rst_req(rst_req)
   );
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              rst_req,
   input logic              en,
   input logic              slow_src,
   input logic              short_to,
   input logic              sel_change,
   input logic              sel_tick
);
   p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en && !slow_src && !short_to));

   p_req_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(sel_tick));

   p_svc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SVC_ADDR) |=> !rst_req);

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !rst_req);

   p_sel_change_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_change |=> !rst_req);
endmodule

bind svc_watchdog svc_watchdog_chk #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rst_req(rst_req),
   .en(cfg.en), .slow_src(cfg.slow_src), .short_to(cfg.short_to),
   .sel_change(sel_change), .sel_tick(sel_tick)
);

// File: tb/svc_watchdog_tb_top.sv
`timescale 1ns/1ps
module svc_watchdog_tb_top;
   localparam int unsigned AW = 8;
   localparam int unsigned DW = 8;
   localparam logic [AW-1:0] A_CTRL = 8'h10;
   localparam logic [AW-1:0] A_SVC  = 8'h14;
   localparam int unsigned L_BL = 9, L_BS = 5, L_SL = 6, L_SS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic bus_tick = 1'b0;
   logic slow_tick = 1'b0;
   logic rst_req;

   always #2.5 clk = ~clk;

   svc_watchdog #(
      .ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(A_CTRL), .SVC_ADDR(A_SVC),
      .BUS_LONG_LG(L_BL), .BUS_SHORT_LG(L_BS), .SLOW_LONG_LG(L_SL), .SLOW_SHORT_LG(L_SS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .bus_tick(bus_tick), .slow_tick(slow_tick), .rst_req(rst_req)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R1";

   // reference state built from the requirements
   bit m_en = 1'b1, m_slow = 1'b0, m_short = 1'b0, m_req = 1'b0;
   int m_cnt = 0;

   function automatic int lg_of(bit slow, bit sh);
      if (!slow) return sh ? L_BS : L_BL;
      return sh ? L_SS : L_SL;
   endfunction

   function automatic int term_of(bit slow, bit sh);
      return (1 << lg_of(slow, sh)) - 1;
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s rst_req actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit ctrl, svc, chg, tk, nreq;
      if (!rst_n) begin
         m_en = 1'b1; m_slow = 1'b0; m_short = 1'b0; m_cnt = 0; m_req = 1'b0;
         return;
      end
      ctrl = wr_en && wr_addr == A_CTRL;
      svc  = wr_en && wr_addr == A_SVC;
      chg  = ctrl && (wr_data[1] != m_slow || wr_data[2] != m_short);
      tk   = m_slow ? slow_tick : bus_tick;
      nreq = 1'b0;
      if (!m_en || chg || svc) m_cnt = 0;
      else if (tk) begin
         if (m_cnt == term_of(m_slow, m_short)) begin m_cnt = 0; nreq = 1'b1; end
         else m_cnt++;
      end
      if (ctrl) begin m_en = wr_data[0]; m_slow = wr_data[1]; m_short = wr_data[2]; end
      m_req = nreq;
   endtask

   task automatic cyc(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit bt, bit st);
      wr_en = w; wr_addr = a; wr_data = d; bus_tick = bt; slow_tick = st;
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag, rst_req, m_req);
   endtask

   task automatic idle_ticks(int n, bit bt, bit st);
      for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, bt, st);
   endtask

   // time from a clear to the request in one mode
   task automatic measure(bit slow, bit sh, bit write_ctrl);
      int n;
      if (write_ctrl) cyc(1'b1, A_CTRL, {5'b0, sh, slow, 1'b1}, 1'b0, 1'b0);
      cyc(1'b1, A_SVC, 8'h5A, 1'b0, 1'b0);
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         cyc(1'b0, '0, '0, !slow, slow);
         n++;
         if (rst_req) break;
      end
      checks++;
      if (n != (1 << lg_of(slow, sh))) begin
         errors++;
         $display("FAIL R4 ticks-to-request actual=%0d expected=%0d (slow=%0b short=%0b)",
                  n, 1 << lg_of(slow, sh), slow, sh);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      // R1: quiet during reset, then default long bus timeout
      tag = "R1";
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) cyc(1'b0, '0, '0, 1'b1, 1'b1);
      rst_n = 1'b1;
      tag = "R1";
      measure(1'b0, 1'b0, 1'b0);
      // R4: all four modes, R5 checked by the per-cycle model
      tag = "R4";
      measure(1'b0, 1'b1, 1'b1);
      measure(1'b1, 1'b0, 1'b1);
      measure(1'b1, 1'b1, 1'b1);
      measure(1'b0, 1'b0, 1'b1);
      tag = "R5";
      idle_ticks(3 * (1 << L_BL), 1'b1, 1'b0);
      // R2: bus selected, slow ticks only
      tag = "R2";
      cyc(1'b1, A_CTRL, 8'h05, 1'b0, 1'b0);
      idle_ticks(200, 1'b0, 1'b1);
      cyc(1'b1, A_CTRL, 8'h07, 1'b0, 1'b0);
      idle_ticks(200, 1'b1, 1'b0);
      // R9: service in the terminal tick cycle
      tag = "R9";
      cyc(1'b1, A_CTRL, 8'h01, 1'b0, 1'b0);
      cyc(1'b1, A_CTRL, 8'h03, 1'b0, 1'b0);
      cyc(1'b1, A_SVC, 8'h00, 1'b0, 1'b0);
      idle_ticks((1 << L_SL) - 1, 1'b0, 1'b1);
      cyc(1'b1, A_SVC, 8'hFF, 1'b0, 1'b1);
      check("R9", rst_req, 1'b0);
      idle_ticks((1 << L_SL) - 1, 1'b0, 1'b1);
      check("R9", rst_req, 1'b0);
      idle_ticks(2, 1'b0, 1'b1);
      // R3: services carrying assorted data
      tag = "R3";
      for (int k = 0; k < 20; k++) begin
         idle_ticks((1 << L_SL) - 2, 1'b0, 1'b1);
         cyc(1'b1, A_SVC, 8'($urandom), 1'b0, 1'b1);
      end
      // R7: same-value rewrite keeps the count, real change clears it
      tag = "R7";
      cyc(1'b1, A_SVC, 8'h00, 1'b0, 1'b0);
      idle_ticks((1 << L_SL) - 2, 1'b0, 1'b1);
      cyc(1'b1, A_CTRL, 8'h03, 1'b0, 1'b1);
      cyc(1'b0, '0, '0, 1'b0, 1'b1);
      check("R7", rst_req, 1'b1);
      idle_ticks((1 << L_SL) - 2, 1'b0, 1'b1);
      cyc(1'b1, A_CTRL, 8'h07, 1'b0, 1'b1);
      idle_ticks((1 << L_SS) - 1, 1'b0, 1'b1);
      check("R7", rst_req, 1'b0);
      // R6: disabled, ticks and services do nothing
      tag = "R6";
      cyc(1'b1, A_CTRL, 8'h00, 1'b1, 1'b1);
      for (int i = 0; i < 1200; i++) cyc(i % 97 == 0, A_SVC, 8'($urandom), 1'b1, 1'b1);
      cyc(1'b1, A_CTRL, 8'h05, 1'b0, 1'b0);
      // R8: stray addresses
      tag = "R8";
      cyc(1'b1, A_SVC, 8'h00, 1'b0, 1'b0);
      for (int i = 0; i < (1 << L_BS) + 4; i++) begin
         logic [AW-1:0] a;
         a = 8'($urandom);
         if (a == A_CTRL || a == A_SVC) a = 8'h77;
         cyc(1'b1, a, 8'($urandom), 1'b1, 1'b0);
      end
      // random mixture
      tag = "R5";
      for (int i = 0; i < 40000; i++) begin
         int r;
         bit w;
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         r = int'($urandom % 1000);
         w = 1'b0; a = '0; d = 8'($urandom);
         if (r < 4) begin w = 1'b1; a = A_CTRL; d = {5'b0, 2'($urandom), ($urandom % 8) != 0}; end
         else if (r < 12) begin w = 1'b1; a = A_SVC; end
         else if (r < 16) begin w = 1'b1; a = 8'h33; end
         cyc(w, a, d, ($urandom % 4) != 0, ($urandom % 16) == 0);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule